// File: doc/BRIEF.md
# Coded-Check Single-Channel FFT Repair Unit

This block sits behind a bank of parallel FFT cores and repairs the output of one faulty core. It takes the output samples of the NCH original cores, the output of one extra redundancy core that transforms the sum of all NCH inputs, and the fail flags of a small set of sum-of-squares (energy) checks. Each check watches a coded group of channels. By linearity, the redundancy core's output equals the sum of the correct channel outputs, so any one channel can be rebuilt from it and the other channels.

The fail flags form a syndrome. Every channel has its own nonzero membership pattern across the checks, so a single faulty channel makes a flag pattern that names it. When the syndrome matches a channel, the block replaces that channel's sample with the redundancy output minus the other channels. An all-clear syndrome passes the data through unchanged. A syndrome that matches no channel raises an uncorrectable flag and also passes the data through unchanged. Results are registered, with one cycle of latency.

Top module: `sosecc_repair`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `err_valid` and `uncorr` are 0, and all output samples are 0.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` is high. `err_valid` and `uncorr` are only ever high together with `out_valid`.
- R3: With `in_valid` high and `chk_fail` = 000, every channel's real and imaginary sample appears unchanged one cycle later, and `err_valid` and `uncorr` stay 0.
- R4: The check membership patterns, written as `chk_fail[2:0]`, are 011 for channel 0, 101 for channel 1, 110 for channel 2 and 111 for channel 3. A syndrome equal to one of these raises `err_valid` with `err_chan` set to that channel.
- R5: The repaired channel's sample is the redundancy sample minus the sum of the other three channel samples. Real and imaginary parts are computed separately in signed arithmetic of width DW+log2(NCH), and the low DW bits are kept.
- R6: During a repair, the channels that were not located pass through unchanged.
- R7: A nonzero syndrome that matches no pattern (001, 010 or 100) raises `uncorr`, leaves `err_valid` at 0, and passes all channels through unchanged.
- R8: A repair is exact at the extremes of the sample range, for example four channels at -128 or at +127 with 8-bit samples, where the redundancy sample exceeds the channel width.
- R9: While `in_valid` is low, the output samples and `err_chan` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The input samples and check flags are valid this cycle |
| ch_re | input | NCH*DW | Real parts of the channel samples; channel c occupies bits [c*DW +: DW], signed |
| ch_im | input | NCH*DW | Imaginary parts of the channel samples, with the same packing |
| par_re | input | PW | Real part of the redundancy core sample, signed, PW = DW+log2(NCH) |
| par_im | input | PW | Imaginary part of the redundancy core sample |
| chk_fail | input | NCHK | Energy-check fail flags; bit i is 1 when check i failed |
| out_valid | output | 1 | The output samples are valid |
| out_re | output | NCH*DW | Real parts of the repaired samples |
| out_im | output | NCH*DW | Imaginary parts of the repaired samples |
| err_valid | output | 1 | A channel was located and repaired |
| err_chan | output | IW | Index of the repaired channel |
| uncorr | output | 1 | The syndrome matches no channel |

## Verification
The hardest case to reach from the ports is a repair at the edges of the sample range. There the redundancy sample needs more bits than a channel, and a narrow datapath would wrap. The bench builds every stimulus from a set of true channel values. It computes the redundancy sample as their exact sum, then corrupts one channel by a chosen offset and applies the matching syndrome. A repair counts as correct only when it recovers the true value, including the directed cases with all channels at -128 or at +127 and large offsets.

// File: rtl/sosecc_pkg.sv
package sosecc_pkg;

    // Outcome of decoding the check syndrome
    typedef struct packed {
        logic       clean;   // syndrome all zero
        logic       hit;     // syndrome matches one channel
        logic       bad;     // nonzero, matches no channel
        logic [7:0] idx;     // located channel when hit
    } verdict_t;

    function automatic int unsigned popcount32(input int unsigned v);
        int unsigned n;
        n = 0;
        for (int b = 0; b < 32; b++) n += (v >> b) & 1;
        return n;
    endfunction

    // Membership pattern of channel j: the j-th code word with at least
    // two ones, so no single flipped flag can alias a channel.
    function automatic int unsigned chan_pattern(input int j);
        int unsigned found;
        int unsigned word;
        found = 0;
        word  = 0;
        for (int unsigned w = 1; w < 256; w++) begin
            if (popcount32(w) >= 2) begin
                if (found == int'(j) && word == 0) word = w;
                found++;
            end
        end
        return word;
    endfunction

endpackage

// File: rtl/sosecc_syndrome_dec.sv
module sosecc_syndrome_dec
    import sosecc_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NCHK = 3
) (
    input  logic [NCHK-1:0] syn,
    output verdict_t        verdict
);

    always_comb begin
        verdict       = '0;
        verdict.clean = (syn == '0);
        for (int j = 0; j < NCH; j++) begin
            if (syn == NCHK'(chan_pattern(j))) begin
                verdict.hit = 1'b1;
                verdict.idx = 8'(j);
            end
        end
        verdict.bad = !verdict.clean && !verdict.hit;
    end

    // R4 R7: exactly one decode outcome per syndrome
    always_comb begin
        verdict_onehot_chk: assert ($onehot({verdict.clean, verdict.hit, verdict.bad}));
    end

endmodule

// File: rtl/sosecc_rebuild.sv
module sosecc_rebuild #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int PW  = 10
) (
    input  logic [NCH*DW-1:0] ch,
    input  logic [PW-1:0]     par,
    output logic [NCH*DW-1:0] rec
);

    // One candidate per channel: redundancy minus every other channel
    for (genvar j = 0; j < NCH; j++) begin : g_cand
        logic signed [PW-1:0] acc;
        always_comb begin
            acc = $signed(par);
            for (int i = 0; i < NCH; i++) begin
                if (i != j) acc = acc - PW'($signed(ch[i*DW +: DW]));
            end
        end
        assign rec[j*DW +: DW] = acc[DW-1:0];
    end

endmodule

// File: rtl/sosecc_repair.sv
module sosecc_repair
    import sosecc_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int DW   = 8,
    parameter int NCHK = 3,
    localparam int LGN = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PW  = DW + LGN,
    localparam int IW  = LGN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [NCH*DW-1:0] ch_re,
    input  logic [NCH*DW-1:0] ch_im,
    input  logic [PW-1:0]     par_re,
    input  logic [PW-1:0]     par_im,
    input  logic [NCHK-1:0]   chk_fail,
    output logic              out_valid,
    output logic [NCH*DW-1:0] out_re,
    output logic [NCH*DW-1:0] out_im,
    output logic              err_valid,
    output logic [IW-1:0]     err_chan,
    output logic              uncorr
);

    verdict_t          verdict;
    logic [NCH*DW-1:0] rec_re, rec_im;
    logic [NCH*DW-1:0] sel_re, sel_im;

    sosecc_syndrome_dec #(.NCH(NCH), .NCHK(NCHK)) dec_i (
        .syn     (chk_fail),
        .verdict (verdict)
    );

    sosecc_rebuild #(.NCH(NCH), .DW(DW), .PW(PW)) rb_re_i (
        .ch (ch_re), .par (par_re), .rec (rec_re)
    );

    sosecc_rebuild #(.NCH(NCH), .DW(DW), .PW(PW)) rb_im_i (
        .ch (ch_im), .par (par_im), .rec (rec_im)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_sel
        logic pick;
        assign pick = verdict.hit && (verdict.idx == 8'(c));
        assign sel_re[c*DW +: DW] = pick ? rec_re[c*DW +: DW] : ch_re[c*DW +: DW];
        assign sel_im[c*DW +: DW] = pick ? rec_im[c*DW +: DW] : ch_im[c*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            err_valid <= 1'b0;
            uncorr    <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
            err_chan  <= '0;
        end else begin
            out_valid <= in_valid;
            err_valid <= in_valid && verdict.hit;
            uncorr    <= in_valid && verdict.bad;
            if (in_valid) begin
                out_re   <= sel_re;
                out_im   <= sel_im;
                err_chan <= verdict.idx[IW-1:0];
            end
        end
    end

    // R2
    lat_one_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    flag_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (err_valid || uncorr) |-> out_valid);

    // R3
    clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && chk_fail == '0) |=>
            (!err_valid && !uncorr && out_re == $past(ch_re) && out_im == $past(ch_im)));

    // R7
    bad_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && verdict.bad) |=>
            (uncorr && !err_valid && out_re == $past(ch_re) && out_im == $past(ch_im)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_re) && $stable(out_im) && $stable(err_chan)));

endmodule

// File: tb/sosecc_repair_tb.sv
module sosecc_repair_tb_top;

    localparam int NCH = 4, DW = 8, NCHK = 3, PW = 10, IW = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [NCH*DW-1:0] ch_re, ch_im;
    logic [PW-1:0]     par_re, par_im;
    logic [NCHK-1:0]   chk_fail;
    logic              out_valid, err_valid, uncorr;
    logic [NCH*DW-1:0] out_re, out_im;
    logic [IW-1:0]     err_chan;

    always #2.5 clk = ~clk;

    sosecc_repair #(.NCH(NCH), .DW(DW), .NCHK(NCHK)) dut_i (
        .clk, .rst, .in_valid, .ch_re, .ch_im, .par_re, .par_im, .chk_fail,
        .out_valid, .out_re, .out_im, .err_valid, .err_chan, .uncorr
    );

    int checks = 0;
    int fails  = 0;

    // {syndrome[20:18], faulty channel[17:16], offset[15:8], base[7:0]}
    localparam logic [20:0] VEC [0:9] = '{
        {3'b000, 2'd0, 8'h00, 8'h11},
        {3'b011, 2'd0, 8'h40, 8'h22},
        {3'b101, 2'd1, 8'h7F, 8'h93},
        {3'b110, 2'd2, 8'h01, 8'h80},
        {3'b111, 2'd3, 8'hC5, 8'h5A},
        {3'b001, 2'd2, 8'h10, 8'h33},
        {3'b010, 2'd1, 8'h20, 8'h44},
        {3'b100, 2'd3, 8'h30, 8'h99},
        {3'b011, 2'd0, 8'h80, 8'h7F},
        {3'b000, 2'd0, 8'h00, 8'hF0}
    };

    logic [7:0] true_re [NCH], true_im [NCH];
    logic [7:0] in_re   [NCH], in_im   [NCH];

    // Channel named by a syndrome per R4, -1 when none
    function automatic int pat_chan(input logic [2:0] s);
        case (s)
            3'b011:  return 0;
            3'b101:  return 1;
            3'b110:  return 2;
            3'b111:  return 3;
            default: return -1;
        endcase
    endfunction

    // Apply true values, corrupt one channel, present for one cycle
    task automatic present(input int fch, input logic [7:0] delta, input logic [2:0] syn);
        int sr, si;
        sr = 0; si = 0;
        for (int c = 0; c < NCH; c++) begin
            sr += int'($signed(true_re[c]));
            si += int'($signed(true_im[c]));
            in_re[c] = true_re[c];
            in_im[c] = true_im[c];
        end
        in_re[fch] = true_re[fch] + delta;
        in_im[fch] = true_im[fch] - delta;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            ch_re[c*DW +: DW] = in_re[c];
            ch_im[c*DW +: DW] = in_im[c];
        end
        par_re   = PW'(sr);
        par_im   = PW'(si);
        chk_fail = syn;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_data(input string tag, input logic use_true);
        logic ok;
        ok = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            logic [7:0] er, ei;
            er = use_true ? true_re[c] : in_re[c];
            ei = use_true ? true_im[c] : in_im[c];
            if (out_re[c*DW +: DW] !== er || out_im[c*DW +: DW] !== ei) begin
                ok = 1'b0;
                $display("FAIL %s ch%0d: got re=%0d im=%0d expected re=%0d im=%0d", tag, c,
                         $signed(out_re[c*DW +: DW]), $signed(out_im[c*DW +: DW]),
                         $signed(er), $signed(ei));
            end
        end
        checks++;
        if (!ok) fails++;
    endtask

    task automatic check_flags(input string tag, input logic ev, input logic [IW-1:0] ec,
                               input logic uc);
        checks++;
        if (out_valid !== 1'b1 || err_valid !== ev || uncorr !== uc || (ev && err_chan !== ec)) begin
            fails++;
            $display("FAIL %s flags: got v=%b ev=%b ch=%0d uc=%b expected v=1 ev=%b ch=%0d uc=%b",
                     tag, out_valid, err_valid, err_chan, uncorr, ev, ec, uc);
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; chk_fail = '0;
        ch_re = '1; ch_im = '1; par_re = '1; par_im = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || err_valid !== 1'b0 || uncorr !== 1'b0 ||
            out_re !== '0 || out_im !== '0) begin
            fails++;
            $display("FAIL R1 reset: got v=%b ev=%b uc=%b re=%h expected 0 0 0 0",
                     out_valid, err_valid, uncorr, out_re);
        end
        rst = 1'b0;

        // Table walk
        for (int n = 0; n < 10; n++) begin
            logic [2:0] syn;
            int fch, m;
            logic [7:0] delta, base;
            syn = VEC[n][20:18]; fch = int'(VEC[n][17:16]);
            delta = VEC[n][15:8]; base = VEC[n][7:0];
            for (int c = 0; c < NCH; c++) begin
                true_re[c] = base + 8'(c * 53);
                true_im[c] = ~base + 8'(c * 29);
            end
            present(fch, delta, syn);
            m = pat_chan(syn);
            if (syn == 3'b000) begin
                check_data("R3 clean pass", 1'b1);
                check_flags("R3 clean", 1'b0, '0, 1'b0);
            end else if (m >= 0) begin
                check_data("R5 R6 repair", 1'b1);
                check_flags("R4 locate", 1'b1, IW'(m), 1'b0);
            end else begin
                check_data("R7 uncorrectable pass", 1'b0);
                check_flags("R7 uncorrectable", 1'b0, '0, 1'b1);
            end
        end

        // R2: no output strobe in the cycle after an idle cycle
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || err_valid !== 1'b0 || uncorr !== 1'b0) begin
            fails++;
            $display("FAIL R2 idle: got v=%b ev=%b uc=%b expected 0 0 0",
                     out_valid, err_valid, uncorr);
        end

        // R8: extremes, all channels at -128, channel 3 corrupted
        for (int c = 0; c < NCH; c++) begin true_re[c] = 8'h80; true_im[c] = 8'h80; end
        present(3, 8'hFF, 3'b111);
        check_data("R8 negative extreme", 1'b1);
        check_flags("R8 negative extreme", 1'b1, 2'd3, 1'b0);

        // R8: all channels at +127, channel 1 corrupted
        for (int c = 0; c < NCH; c++) begin true_re[c] = 8'h7F; true_im[c] = 8'h7F; end
        present(1, 8'h81, 3'b101);
        check_data("R8 positive extreme", 1'b1);
        check_flags("R8 positive extreme", 1'b1, 2'd1, 1'b0);

        // R9: inputs change with in_valid low, outputs hold
        @(negedge clk);
        ch_re = '0; ch_im = '0; par_re = '0; par_im = '0; chk_fail = 3'b011;
        repeat (2) @(negedge clk);
        checks++;
        if (out_re[DW +: DW] !== 8'h7F || out_im[DW +: DW] !== 8'h7F || err_chan !== 2'd1) begin
            fails++;
            $display("FAIL R9 hold: got re1=%h im1=%h ch=%0d expected 7f 7f 1",
                     out_re[DW +: DW], out_im[DW +: DW], err_chan);
        end

        // R2: back-to-back samples keep out_valid high each cycle
        in_valid = 1'b1; chk_fail = 3'b000;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1) begin
            fails++;
            $display("FAIL R2 latency: got v=%b expected 1", out_valid);
        end
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b1 || out_re !== '0) begin
            fails++;
            $display("FAIL R2 streaming: got v=%b re=%h expected 1 0", out_valid, out_re);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule